// File: doc/BRIEF.md
# Error-Correcting SRAM Wrapper with Test Modes

This block wraps a single-port RAM that keeps each data word next to its single-error-correct, double-error-detect check bits. A client issues read and write requests on a simple valid/ready interface. Writes store the data with freshly generated check bits. Reads return the corrected word one cycle later, with a flag that says whether a single-bit error was repaired and a flag that says whether an uncorrectable error was seen.

A two-bit test-mode input lets software build faulty codewords on purpose and look at them. One mode writes only the data half and leaves the stored check bits as they were. Another writes only the check-bit half from the low bits of the write data. In both of these modes checking is turned off, so the raw stored contents can be read back. An init request fills the whole array with zero data and the matching check bits, one address per clock. Client requests are held off while the fill runs, and a done level is raised when it ends.

Top module: `ecc_sram_wrap`

## Requirements
- R1: During and right after reset, rsp_valid, init_done, rsp_corr and rsp_uncorr are 0, rsp_rdata is 0, and req_ready is 1 while init_start is low.
- R2: A read accepted at a clock edge (req_valid, req_ready and not req_write) gives rsp_valid = 1 exactly one cycle later, with rsp_rdata and both flags valid in that cycle. rsp_valid is 0 in every other cycle.
- R3: Test modes 0 and 3 behave the same. A write stores the data and its 7 check bits. For check bit i (i = 0..5), data bit k sits at codeword position p(k), the k-th integer from 1 upward that is not a power of two, and bit i is the XOR of the data bits whose p(k) has bit i set. Bit 6 is the XOR of all data bits and check bits 0..5. A read of a clean word returns it with both flags 0.
- R4: In modes 0 and 3, a stored codeword with exactly one flipped bit is read back as the original data with rsp_corr = 1 and rsp_uncorr = 0. This holds whether the flipped bit is in the data or in the check bits.
- R5: In modes 0 and 3, a stored codeword that is not within one bit of any valid codeword sets rsp_uncorr = 1 and rsp_corr = 0, and rsp_rdata returns the stored data unmodified.
- R6: In mode 1, a write replaces only the stored data bits and keeps the stored check bits. A read returns the stored data without correction, and both flags are 0.
- R7: In mode 2, a write replaces only the stored check bits with req_wdata[6:0] and keeps the stored data. A read returns the stored check bits zero-extended to 32 bits, and both flags are 0.
- R8: init_start while idle writes zero data with its check bits to addresses 0 through 63, one address per cycle. init_done falls at the start and rises in the cycle after the last address is written, then stays high until the next accepted init_start.
- R9: req_ready is 0 while the fill runs and in any cycle where init_start is high. init_start is ignored while a fill is running.
- R10: The test mode that applies to a read is the value present when the read is accepted. A mode change in the response cycle has no effect on that response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| test_mode | input | 2 | 0/3 normal, 1 keep check bits, 2 keep data bits |
| init_start | input | 1 | Starts a fill of the whole array |
| init_done | output | 1 | High once a fill has completed |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_rdata | output | 32 | Read data |
| rsp_corr | output | 1 | A single-bit error was corrected |
| rsp_uncorr | output | 1 | An uncorrectable error was detected |

## Verification
An init request and a client request can arrive in the same cycle. The bench raises init_start together with a valid read, and later pulses init_start again in the middle of a running fill. The reference model expects the request to be refused (req_ready low and no response), the fill to start, and the second pulse to leave the done timing unchanged. Every cycle, the model's ready, done, response and flags are compared with the outputs of the design.

// File: rtl/ecc_sram_pkg.sv
package ecc_sram_pkg;

   typedef enum logic [1:0] {
      TM_NORMAL     = 2'd0,
      TM_KEEP_CHK   = 2'd1,
      TM_KEEP_DATA  = 2'd2,
      TM_NORMAL_ALT = 2'd3
   } tmode_e;

   // number of Hamming bits needed for dw data bits
   function automatic int ham_bits(input int dw);
      int p;
      p = 0;
      while ((1 << p) < dw + p + 1) p++;
      return p;
   endfunction

   function automatic bit is_pow2(input int v);
      return (v & (v - 1)) == 0;
   endfunction

   // codeword position (1-based) of data bit k
   function automatic int data_pos(input int k);
      int pos;
      int seen;
      pos  = 0;
      seen = -1;
      while (seen < k) begin
         pos++;
         if (!is_pow2(pos)) seen++;
      end
      return pos;
   endfunction

endpackage

// File: rtl/ecc_enc.sv
module ecc_enc
   import ecc_sram_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int HAM_W  = 6,
   localparam int CHK_W = HAM_W + 1
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [CHK_W-1:0]  chk_o
);

   logic [HAM_W-1:0] ham;

   always_comb begin
      ham = '0;
      for (int i = 0; i < HAM_W; i++) begin
         for (int k = 0; k < DATA_W; k++) begin
            if (((data_pos(k) >> i) & 1) == 1) ham[i] = ham[i] ^ data_i[k];
         end
      end
   end

   assign chk_o = {^{data_i, ham}, ham};

endmodule

// File: rtl/ecc_dec.sv
module ecc_dec
   import ecc_sram_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int HAM_W  = 6,
   localparam int CHK_W = HAM_W + 1,
   localparam int CW_N  = DATA_W + HAM_W
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [CHK_W-1:0]  chk_i,
   output logic [DATA_W-1:0] data_o,
   output logic              corr_o,
   output logic              uncorr_o
);

   logic [CHK_W-1:0]  recalc;
   logic [HAM_W-1:0]  syn;
   logic              odd;
   logic [DATA_W-1:0] flip;

   ecc_enc #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_recalc (
      .data_i (data_i),
      .chk_o  (recalc)
   );

   assign syn = chk_i[HAM_W-1:0] ^ recalc[HAM_W-1:0];
   assign odd = ^{data_i, chk_i};

   always_comb begin
      flip     = '0;
      corr_o   = 1'b0;
      uncorr_o = 1'b0;
      if (odd) begin
         if (syn == '0) begin
            corr_o = 1'b1;
         end else if (int'(syn) <= CW_N) begin
            corr_o = 1'b1;
            for (int k = 0; k < DATA_W; k++) begin
               if (data_pos(k) == int'(syn)) flip[k] = 1'b1;
            end
         end else begin
            uncorr_o = 1'b1;
         end
      end else if (syn != '0) begin
         uncorr_o = 1'b1;
      end
   end

   assign data_o = data_i ^ flip;

endmodule

// File: rtl/ecc_store.sv
module ecc_store #(
   parameter int DATA_W = 32,
   parameter int CHK_W  = 7,
   parameter int ADDR_W = 6,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              rd_i,
   input  logic              wr_data_i,
   input  logic              wr_chk_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [CHK_W-1:0]  wchk_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic [CHK_W-1:0]  rchk_o
);

   logic [DATA_W-1:0] dmem [DEPTH];
   logic [CHK_W-1:0]  cmem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_data_i) dmem[addr_i] <= wdata_i;
      if (wr_chk_i)  cmem[addr_i] <= wchk_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_o <= '0;
         rchk_o  <= '0;
      end else if (rd_i) begin
         rdata_o <= dmem[addr_i];
         rchk_o  <= cmem[addr_i];
      end
   end

endmodule

// File: rtl/ecc_fill_seq.sv
module ecc_fill_seq #(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [ADDR_W-1:0] addr_o
);

   localparam logic [ADDR_W-1:0] LAST = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         done_o <= 1'b0;
         addr_o <= '0;
      end else if (busy_o) begin
         if (addr_o == LAST) begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
         end
         addr_o <= addr_o + 1'b1;
      end else if (start_i) begin
         busy_o <= 1'b1;
         done_o <= 1'b0;
         addr_o <= '0;
      end
   end

   AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && $past(busy_o) |-> addr_o == ADDR_W'($past(addr_o) + 1'b1)); // R8
   AST_DONE_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o); // R8
   AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> !done_o && addr_o == '0); // R8

endmodule

// File: rtl/ecc_sram_wrap.sv
module ecc_sram_wrap
   import ecc_sram_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 6,
   localparam int HAM_W = ham_bits(DATA_W),
   localparam int CHK_W = HAM_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        test_mode,
   input  logic              init_start,
   output logic              init_done,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_corr,
   output logic              rsp_uncorr
);

   if (DATA_W < CHK_W) begin : g_bad_width
      $error("DATA_W must be able to carry the check bits in the check-bit test mode");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be at least 1");
   end

   tmode_e            mode, mode_q;
   logic              fill_busy;
   logic [ADDR_W-1:0] fill_addr;
   logic              accept, rd_go;
   logic              wr_data, wr_chk;
   logic [ADDR_W-1:0] mem_addr;
   logic [DATA_W-1:0] mem_wdata, mem_rdata, fixed_data;
   logic [CHK_W-1:0]  gen_chk, zero_chk, mem_wchk, mem_rchk;
   logic              dec_corr, dec_uncorr;

   assign mode      = tmode_e'(test_mode);
   assign req_ready = !fill_busy && !init_start;
   assign accept    = req_valid && req_ready;
   assign rd_go     = accept && !req_write;

   ecc_fill_seq #(.ADDR_W(ADDR_W)) u_fill (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (init_start),
      .busy_o  (fill_busy),
      .done_o  (init_done),
      .addr_o  (fill_addr)
   );

   ecc_enc #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_enc_wr (
      .data_i (req_wdata),
      .chk_o  (gen_chk)
   );

   ecc_enc #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_enc_zero (
      .data_i ('0),
      .chk_o  (zero_chk)
   );

   always_comb begin
      wr_data   = 1'b0;
      wr_chk    = 1'b0;
      mem_addr  = req_addr;
      mem_wdata = req_wdata;
      mem_wchk  = gen_chk;
      if (fill_busy) begin
         wr_data   = 1'b1;
         wr_chk    = 1'b1;
         mem_addr  = fill_addr;
         mem_wdata = '0;
         mem_wchk  = zero_chk;
      end else if (accept && req_write) begin
         unique case (mode)
            TM_KEEP_CHK:  wr_data = 1'b1;
            TM_KEEP_DATA: begin
               wr_chk   = 1'b1;
               mem_wchk = req_wdata[CHK_W-1:0];
            end
            default: begin
               wr_data = 1'b1;
               wr_chk  = 1'b1;
            end
         endcase
      end
   end

   ecc_store #(.DATA_W(DATA_W), .CHK_W(CHK_W), .ADDR_W(ADDR_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_i    (mem_addr),
      .rd_i      (rd_go),
      .wr_data_i (wr_data),
      .wr_chk_i  (wr_chk),
      .wdata_i   (mem_wdata),
      .wchk_i    (mem_wchk),
      .rdata_o   (mem_rdata),
      .rchk_o    (mem_rchk)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         mode_q    <= TM_NORMAL;
      end else begin
         rsp_valid <= rd_go;
         if (rd_go) mode_q <= mode;
      end
   end

   ecc_dec #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_dec (
      .data_i   (mem_rdata),
      .chk_i    (mem_rchk),
      .data_o   (fixed_data),
      .corr_o   (dec_corr),
      .uncorr_o (dec_uncorr)
   );

   always_comb begin
      unique case (mode_q)
         TM_KEEP_CHK: begin
            rsp_rdata  = mem_rdata;
            rsp_corr   = 1'b0;
            rsp_uncorr = 1'b0;
         end
         TM_KEEP_DATA: begin
            rsp_rdata  = DATA_W'(mem_rchk);
            rsp_corr   = 1'b0;
            rsp_uncorr = 1'b0;
         end
         default: begin
            rsp_rdata  = fixed_data;
            rsp_corr   = dec_corr;
            rsp_uncorr = dec_uncorr;
         end
      endcase
   end

   AST_STALL_WHILE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      fill_busy |-> !req_ready); // R9
   AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !req_write) |=> rsp_valid); // R2
   AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_ready && !req_write) |=> !rsp_valid); // R2
   AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !(rsp_corr && rsp_uncorr)); // R5
   AST_KEEP_CHK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && mode_q == TM_KEEP_CHK |-> !rsp_corr && !rsp_uncorr); // R6
   AST_KEEP_DATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && mode_q == TM_KEEP_DATA |-> !rsp_corr && !rsp_uncorr); // R7

endmodule

// File: tb/ecc_sram_wrap_test.sv
module ecc_sram_wrap_test;

   localparam int DW    = 32;
   localparam int AW    = 6;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    test_mode = 2'd0;
   logic          init_start = 1'b0;
   logic          init_done;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic          rsp_corr;
   logic          rsp_uncorr;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   ecc_sram_wrap uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .test_mode  (test_mode),
      .init_start (init_start),
      .init_done  (init_done),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_write  (req_write),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .rsp_valid  (rsp_valid),
      .rsp_rdata  (rsp_rdata),
      .rsp_corr   (rsp_corr),
      .rsp_uncorr (rsp_uncorr)
   );

   task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // behavioural check-bit generator written from the requirement text
   function automatic logic [6:0] ref_chk(input logic [31:0] d);
      logic [6:0] c;
      int k;
      c = '0;
      k = 0;
      for (int pos = 1; k < 32; pos++) begin
         if ((pos & (pos - 1)) != 0) begin
            for (int i = 0; i < 6; i++) if (pos[i]) c[i] = c[i] ^ d[k];
            k++;
         end
      end
      c[6] = (^d) ^ (^c[5:0]);
      return c;
   endfunction

   // reference model state
   logic [31:0]   md [DEPTH];
   logic [6:0]    mc [DEPTH];
   logic          mbusy, mdone, ev, ecorr, eunc;
   int            mcnt;
   logic [31:0]   edata;
   string         etag;
   logic          cmp_on = 1'b0;

   task automatic ref_read(input logic [31:0] d, input logic [6:0] c, input logic [1:0] m,
                           output logic [31:0] od, output logic oc, output logic ou, output string tg);
      logic found;
      od = d; oc = 1'b0; ou = 1'b0;
      if (m == 2'd1) begin
         tg = "R6";
      end else if (m == 2'd2) begin
         od = {25'b0, c};
         tg = "R7";
      end else if (ref_chk(d) == c) begin
         tg = "R3";
      end else begin
         found = 1'b0;
         for (int b = 0; b < 39; b++) begin
            logic [31:0] td;
            logic [6:0]  tc;
            td = d; tc = c;
            if (b < 32) td[b] = ~td[b]; else tc[b-32] = ~tc[b-32];
            if (!found && ref_chk(td) == tc) begin
               found = 1'b1;
               od = td;
            end
         end
         if (found) begin oc = 1'b1; tg = "R4"; end
         else begin ou = 1'b1; od = d; tg = "R5"; end
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         mbusy <= 1'b0; mdone <= 1'b0; ev <= 1'b0; mcnt <= 0;
         ecorr <= 1'b0; eunc <= 1'b0; edata <= '0;
      end else begin
         ev <= 1'b0;
         if (mbusy) begin
            md[mcnt] <= 32'h0;
            mc[mcnt] <= ref_chk(32'h0);
            if (mcnt == DEPTH - 1) begin mbusy <= 1'b0; mdone <= 1'b1; end
            mcnt <= (mcnt + 1) % DEPTH;
         end else if (init_start) begin
            mbusy <= 1'b1; mcnt <= 0; mdone <= 1'b0;
         end else if (req_valid) begin
            if (req_write) begin
               if (test_mode == 2'd1) md[req_addr] <= req_wdata;
               else if (test_mode == 2'd2) mc[req_addr] <= req_wdata[6:0];
               else begin
                  md[req_addr] <= req_wdata;
                  mc[req_addr] <= ref_chk(req_wdata);
               end
            end else begin
               logic [31:0] od; logic oc, ou; string tg;
               ref_read(md[req_addr], mc[req_addr], test_mode, od, oc, ou, tg);
               ev <= 1'b1; edata <= od; ecorr <= oc; eunc <= ou; etag <= tg;
            end
         end
      end
   end

   // cycle-by-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && cmp_on) begin
         check(64'(req_ready), 64'(!mbusy && !init_start), "R9", "req_ready");
         check(64'(init_done), 64'(mdone), "R8", "init_done");
         check(64'(rsp_valid), 64'(ev), "R2", "rsp_valid");
         if (ev) begin
            check(64'(rsp_rdata), 64'(edata), etag, "rsp_rdata");
            check(64'({rsp_corr, rsp_uncorr}), 64'({ecorr, eunc}), etag, "flags corr/uncorr");
         end
      end
   end

   task automatic drive(input logic v, input logic w, input int a, input logic [31:0] d,
                        input logic [1:0] m, input logic st);
      @(negedge clk);
      #1;
      req_valid = v; req_write = w; req_addr = AW'(a); req_wdata = d;
      test_mode = m; init_start = st;
   endtask

   task automatic wr(input int a, input logic [31:0] d, input logic [1:0] m);
      drive(1'b1, 1'b1, a, d, m, 1'b0);
   endtask

   task automatic rd(input int a, input logic [1:0] m);
      drive(1'b1, 1'b0, a, 32'h0, m, 1'b0);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 0, 32'h0, 2'd0, 1'b0);
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset values while rst_n low
      check(64'(rsp_valid), 64'd0, "R1", "rsp_valid in reset");
      check(64'(init_done), 64'd0, "R1", "init_done in reset");
      check(64'(req_ready), 64'd1, "R1", "req_ready in reset");
      check(64'({rsp_corr, rsp_uncorr}), 64'd0, "R1", "flags in reset");
      check(64'(rsp_rdata), 64'd0, "R1", "rsp_rdata in reset");
      #1 rst_n = 1'b1;
      cmp_on = 1'b1;
      idle(2);

      // R9: init_start together with a read request; request must be refused
      drive(1'b1, 1'b0, 3, 32'h0, 2'd0, 1'b1);
      idle(20);
      drive(1'b0, 1'b0, 0, 32'h0, 2'd0, 1'b1);   // ignored pulse mid-fill (R9)
      idle(50);
      // R8: after the fill every word reads as clean zero
      rd(0, 2'd0);
      rd(63, 2'd0);
      rd(17, 2'd3);

      // R3: normal writes and reads in modes 0 and 3
      wr(5, 32'hDEADBEEF, 2'd0);
      wr(6, 32'h12345678, 2'd3);
      wr(63, 32'hFFFFFFFF, 2'd0);
      wr(0, 32'h00000001, 2'd0);
      rd(5, 2'd0);
      rd(6, 2'd0);
      rd(63, 2'd3);
      rd(0, 2'd3);

      // R6: data-only writes build single and double errors
      wr(5, 32'hDEADBEEF ^ 32'h00000080, 2'd1);
      wr(6, 32'h12345678 ^ 32'h00000030, 2'd1);
      rd(5, 2'd1);
      rd(5, 2'd0);   // R4 corrected data bit
      rd(6, 2'd0);   // R5 double error
      rd(6, 2'd1);

      // R7: check-only writes
      wr(63, 32'({25'b0, ref_chk(32'hFFFFFFFF) ^ 7'h04}), 2'd2);
      wr(0, 32'({25'b0, ref_chk(32'h00000001) ^ 7'h40}), 2'd2);
      wr(9, 32'h0000007F, 2'd2);
      rd(63, 2'd2);
      rd(63, 2'd0);  // R4 corrected check bit
      rd(0, 2'd0);   // R4 overall bit
      rd(9, 2'd0);
      idle(1);

      // R10: mode at acceptance governs the response
      rd(63, 2'd2);
      drive(1'b0, 1'b0, 0, 32'h0, 2'd0, 1'b0);
      check(64'(rsp_rdata), 64'({25'b0, ref_chk(32'hFFFFFFFF) ^ 7'h04}), "R10", "mode held for response");
      check(64'(rsp_valid), 64'd1, "R10", "response present");

      // write then read back to back, mode 3 write
      wr(10, 32'hA5A5_0F0F, 2'd3);
      rd(10, 2'd0);
      rd(10, 2'd1);
      idle(2);

      // R8: second fill wipes earlier contents
      drive(1'b0, 1'b0, 0, 32'h0, 2'd0, 1'b1);
      idle(66);
      rd(5, 2'd0);
      rd(63, 2'd2);
      idle(3);

      cmp_on = 1'b0;
      summary();
      $finish;
   end

endmodule